// File: doc/BRIEF.md
# Composite sync vertical pulse extractor

This block watches a sampled, active-high composite sync level and produces one vertical sync output pulse per field. An integrator counter measures each high interval. It counts clock cycles while the level is high, clears on any low sample, and holds at its maximum instead of wrapping.

The block has two trigger paths:

- **Normal trigger.** A high interval that ends with a count at or above a lower threshold fires when that interval ends. In a standard field this is the end of the first broad vertical pulse, at the first serration.
- **Default trigger.** A high interval that lasts long enough to pass a higher threshold fires while the level is still high. This covers vertical intervals that have no serrations.

Either trigger sets the output flag. While the flag is set, a tick generator with a programmable period runs, and a divide-by-8 stage clears the flag after eight ticks. If the output has already ended when a later qualifying interval ends, that interval starts a second pulse. Thresholds and tick period are run-time inputs measured in clock cycles.

Top module: `vsync_extract`

## Requirements
- R1: A synchronous active-high `rst` clears the integrator, the one-shot flag and the pulse logic. `vs_out` is 0 during reset and stays 0 afterwards while `sync_hi` stays low.
- R2: When a high run of L consecutive high samples, with L >= `thr_lo` and L >= 1, is followed by a low sample, `vs_out` rises on the clock edge that takes that first low sample.
- R3: A high run shorter than `thr_lo` that ends before it reaches the default threshold produces no pulse.
- R4: Each pulse keeps `vs_out` high for exactly 8*P clock cycles, where P = `tick_per`. A `tick_per` of 0 is treated as 1.
- R5: While `sync_hi` is high, the default trigger fires on the edge that takes the high sample following `thr_def` earlier consecutive high samples. That is the (`thr_def`+1)-th high sample of the run, and `vs_out` rises on that edge.
- R6: The default trigger fires at most once per high run, even when the run continues long after the pulse it started has ended.
- R7: If `vs_out` is low when a qualifying run ends, a new pulse starts. This also applies to the end of a run that already fired a default pulse.
- R8: A trigger that arrives while `vs_out` is high has no effect. In particular, the pulse width is not extended or restarted.
- R9: The integrator saturates at 2^CNT_W-1 and does not wrap. A run longer than that still meets a `thr_lo` of 2^CNT_W-1 when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_hi | input | 1 | Sampled composite sync, high during sync |
| thr_lo | input | CNT_W | Minimum high-run length, in cycles, for the normal trigger |
| thr_def | input | CNT_W | High-run length, in cycles, for the default trigger |
| tick_per | input | TICK_W | Tick period in cycles; the output width is 8 ticks |
| vs_out | output | 1 | Vertical sync output pulse |

## Verification
The block is exercised with five kinds of input:

- **Short pulses.** Narrow equalizing-style pulses must yield nothing, which separates the normal threshold from any edge response.
- **Broad-pulse train, long tick.** A train of broad pulses with serrations, run with a long tick, must give a single pulse; this shows that triggers are ignored while the output is high.
- **Broad-pulse train, short tick.** The same train with a short tick must give three pulses, which exposes the retrigger path.
- **Long intervals without serrations.** These separate the default trigger, its once-per-run rule, and the retrigger at the end of the interval. A VGA-like interval instead fires only at its end.
- **Over-long run.** A run longer than the integrator range tells saturation apart from wrap-around.

A behavioural model in the bench, built from run lengths and a remaining-width count, is compared with `vs_out` on every clock.

// File: rtl/vsync_extract.sv
module vsync_extract #(
  parameter int CNT_W  = 16,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_hi,
  input  logic [CNT_W-1:0]  thr_lo,
  input  logic [CNT_W-1:0]  thr_def,
  input  logic [TICK_W-1:0] tick_per,
  output logic              vs_out
);
  localparam int DIV_W = 3;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [DIV_W-1:0] DIV_LAST = {DIV_W{1'b1}};

  logic [CNT_W-1:0]  integ;
  logic              def_done;
  logic [TICK_W-1:0] tcnt;
  logic [DIV_W-1:0]  dcnt;
  logic              vs_q;

  wire edge_trig = !sync_hi && (integ != '0) && (integ >= thr_lo);
  wire def_trig  = sync_hi && !def_done && (integ >= thr_def);
  wire trig      = edge_trig || def_trig;

  wire [TICK_W-1:0] last_t = (tick_per == '0) ? '0 : tick_per - 1'b1;
  wire tick = (tcnt >= last_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      integ    <= '0;
      def_done <= 1'b0;
    end else begin
      if (sync_hi)
        integ <= (integ == CNT_MAX) ? integ : integ + 1'b1;
      else
        integ <= '0;
      def_done <= sync_hi && (def_done || def_trig);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q <= 1'b0;
      tcnt <= '0;
      dcnt <= '0;
    end else if (!vs_q) begin
      tcnt <= '0;
      dcnt <= '0;
      if (trig) vs_q <= 1'b1;
    end else if (tick) begin
      tcnt <= '0;
      dcnt <= dcnt + 1'b1;
      if (dcnt == DIV_LAST) vs_q <= 1'b0;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  assign vs_out = vs_q;
endmodule

module vsync_extract_chk #(
  parameter int CNT_W  = 16,
  parameter int TICK_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_hi,
  input logic [TICK_W-1:0] tick_per,
  input logic              vs_out
);
  logic [TICK_W+3:0] hi_cnt;
  logic [TICK_W+3:0] want_w;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (vs_out) hi_cnt <= hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  always_comb begin
    want_w = (tick_per == '0) ? (TICK_W+4)'(8) : {1'b0, tick_per, 3'b000};
  end

  a_r1_reset_low: assert property (@(posedge clk) rst |=> !vs_out);

  a_r2_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_out) |-> ($past(sync_hi) || ($past(!sync_hi) && $past(sync_hi, 2))));

  a_r2_quiet_stays_low: assert property (@(posedge clk) disable iff (rst)
    (!vs_out && !sync_hi && $past(!sync_hi)) |=> !vs_out);

  a_r4_width_exact: assert property (@(posedge clk) disable iff (rst)
    $fell(vs_out) |-> (hi_cnt == want_w));
endmodule

bind vsync_extract vsync_extract_chk #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_chk (
  .clk(clk), .rst(rst), .sync_hi(sync_hi), .tick_per(tick_per), .vs_out(vs_out)
);

// File: tb/vsync_extract_tb.sv
module vsync_extract_tb_top;
  localparam int CW = 16;
  localparam int TW = 16;
  localparam int CMAX = 65535;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_hi = 1'b0;
  logic [CW-1:0] thr_lo = 16'd20;
  logic [CW-1:0] thr_def = 16'd100;
  logic [TW-1:0] tick_per = 16'd5;
  logic vs_out;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  vsync_extract #(.CNT_W(CW), .TICK_W(TW)) dut_i (
    .clk(clk), .rst(rst), .sync_hi(sync_hi), .thr_lo(thr_lo),
    .thr_def(thr_def), .tick_per(tick_per), .vs_out(vs_out)
  );

  always #5 clk = ~clk;

  // reference model: run length, one-shot, remaining pulse cycles
  int run = 0;
  bit dd = 0;
  int rem = 0;
  bit exp_vs = 0;

  always @(posedge clk) begin
    if (rst) begin
      run = 0; dd = 0; rem = 0;
    end else begin
      int sat;
      bit te, td, fired;
      sat = (run > CMAX) ? CMAX : run;
      te = !sync_hi && run > 0 && sat >= int'(thr_lo);
      td = sync_hi && !dd && sat >= int'(thr_def);
      fired = te || td;
      if (sync_hi) begin
        if (td) dd = 1;
        run++;
      end else begin
        run = 0; dd = 0;
      end
      if (rem > 0) rem--;
      else if (fired) rem = 8 * ((tick_per == 0) ? 1 : int'(tick_per));
    end
    exp_vs = (rem > 0);
  end

  int rises = 0;
  int last_w = 0;
  int cur_w = 0;
  bit prev_vs = 0;

  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (vs_out !== exp_vs) begin
        bad++;
        $display("FAIL %s per-cycle vs_out: got %0b expected %0b at %0t", cur_req, vs_out, exp_vs, $time);
      end
      if (vs_out && !prev_vs) begin rises++; cur_w = 0; end
      if (vs_out) cur_w++;
      if (!vs_out && prev_vs) last_w = cur_w;
      prev_vs = vs_out;
    end
  end

  task automatic hi(input int n);
    sync_hi = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic lo(input int n);
    sync_hi = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int want);
    total++;
    if (got != want) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, want);
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      bad++;
      $display("FAIL watchdog: got %0d cycles expected under 190000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 vs_out during reset", int'(vs_out), 0);
    rst = 1'b0;
    lo(10);
    chk("R1 idle after reset", rises, 0);

    // R3: short pulses never reach thr_lo
    cur_req = "R3";
    rises = 0;
    repeat (5) begin hi(10); lo(30); end
    chk("R3 short pulses", rises, 0);

    // R2/R8: broad train, long tick covers the whole train
    cur_req = "R8";
    tick_per = 16'd30;
    rises = 0;
    repeat (6) begin hi(28); lo(4); end
    lo(260);
    chk("R8 one pulse for broad train", rises, 1);
    chk("R8 width not extended", last_w, 240);

    // R7: short tick gives retriggers on later serrations
    cur_req = "R7";
    tick_per = 16'd5;
    rises = 0;
    repeat (6) begin hi(28); lo(4); end
    lo(60);
    chk("R7 retrigger count", rises, 3);
    chk("R4 width P=5", last_w, 40);

    // R5/R6/R7: long interval without serrations
    cur_req = "R5";
    rises = 0;
    hi(102);
    chk("R5 default pulse fired", rises, 1);
    cur_req = "R6";
    hi(198);
    chk("R6 default once per run", rises, 1);
    cur_req = "R7";
    lo(60);
    chk("R7 retrigger after default", rises, 2);

    // R2: VGA-like, default beyond interval, pulse at end
    cur_req = "R2";
    thr_def = 16'd200;
    rises = 0;
    hi(128);
    chk("R2 no pulse during interval", rises, 0);
    lo(2);
    chk("R2 pulse at end of interval", rises, 1);
    lo(60);

    // R4: tick_per 0 behaves as 1
    cur_req = "R4";
    tick_per = '0;
    rises = 0;
    hi(30); lo(20);
    chk("R4 pulse count P=0", rises, 1);
    chk("R4 width P=0", last_w, 8);

    // R9: saturation instead of wrap
    cur_req = "R9";
    tick_per = 16'd2;
    thr_lo = 16'hFFFF;
    thr_def = 16'hFFFF;
    rises = 0;
    hi(70000);
    chk("R9 default at saturation once", rises, 1);
    lo(40);
    chk("R9 saturated run meets thr_lo", rises, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule